// File: doc/BRIEF.md
# Round-Based Random Permutation Generator

This block issues rule indices for a stochastic network simulator that updates elements in random sequential order, one round at a time. In every round each index from 0 to N-1 appears exactly once, in a random order, one index per accepted transfer. No index is repeated or skipped within a round.

Two register banks hold entries made of a rank and a random value. The fill bank takes one fresh pseudo-random value per step and ranks it against the entries already present. The drain bank supplies the index of the current round. Both banks work on every step, so the next round's order is ready when the current round ends, and the handover costs no cycle. After reset the first round has to be ranked before any index can be issued, which takes N enabled steps.

The index leaves on a valid/ready stream. While `out_valid` is high and `out_ready` is low, the block holds `out_index` and makes no progress. `en` pauses the whole block, including the initial fill.

Top module: `perm_round_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0.
- R2: After reset, `out_valid` stays 0 during the first N cycles with `en` high. From then on, `out_valid` is 1 in every cycle in which `en` is 1, with no gap between rounds.
- R3: The indices accepted in each group of N consecutive handshakes after the fill are all distinct, and together they cover 0..N-1.
- R4: Each step uses a 16-bit right-shifting Galois LFSR. The step takes the low VW bits of the current state as the value, then advances the state: the state shifts right by one, and if the bit shifted out was 1 it is XORed with 0xB400. Values v0..v(N-1) pushed in one round produce ranks r_j = #{k<j : v_k<v_j} + #{k>j : v_k<=v_j}, so equal values rank the earlier push higher. In the following round these ranks are issued in reverse push order: r_(N-1) first, r_0 last.
- R5: In a cycle with `out_valid`=1 and `out_ready`=0, no step occurs, and `out_index` keeps its value into the next cycle.
- R6: While `en` is 0, `out_valid` is 0, no step occurs, and `out_index` does not change. When `en` returns, the sequence resumes exactly where it stopped.
- R7: The LFSR loads `seed` while `rst_n` is low. A zero `seed` is replaced by 0xACE1.
- R8: A step happens on a rising clock edge with `en`=1 and either the fill still in progress or `out_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| seed | input | 16 | LFSR start value, loaded during reset |
| en | input | 1 | Allows steps; when low the block pauses |
| out_ready | input | 1 | Sink accepts the current index |
| out_valid | output | 1 | An index is offered |
| out_index | output | $clog2(N) | Offered rule index |

## Verification
A wrong rank inside the fill bank stays hidden for up to one round. It shows at the ports as a repeated or missing index, or as an order that differs from the computed one, during the round after it was pushed, so within 2N steps. A fault in the slot counter or the phase shows sooner: `out_valid` rises a cycle early or late after reset, or the pop order breaks in the very first round. The bench rebuilds the value stream and the rank formula of R4 arithmetically and compares every accepted index. It does so across several seeds, under back-pressure and while `en` is toggled.

// File: rtl/perm_pkg.sv
package perm_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_ALT_SEED = 16'hACE1;

  typedef enum logic {
    PH_FILL = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s);
    lfsr_adv = s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
  endfunction
endpackage

// File: rtl/perm_lfsr.sv
module perm_lfsr
  import perm_pkg::*;
#(
  parameter int VW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LFSR_W-1:0] seed,
  input  logic              adv,
  output logic [VW-1:0]     value
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= (seed == '0) ? LFSR_ALT_SEED : seed;
    else if (adv) state_q <= lfsr_adv(state_q);
  end

  assign value = state_q[VW-1:0];
endmodule

// File: rtl/perm_fill_stack.sv
module perm_fill_stack #(
  parameter int N  = 16,
  parameter int IW = 4,
  parameter int VW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [IW-1:0]         slot,
  input  logic [VW-1:0]         new_val,
  output logic [N-1:0][IW-1:0]  nxt_pri
);
  logic [N-1:0][IW-1:0] pri_q;
  logic [N-1:0][VW-1:0] val_q;
  logic [N-1:0]         below;   // existing entry ranks under the new one
  logic [N-1:0]         bump;    // existing entry moves up one rank
  logic [IW-1:0]        new_rank;

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam logic [IW-1:0] POS = IW'(i);
    logic live;
    assign live     = POS < slot;
    assign below[i] = live && (val_q[i] < new_val);
    assign bump[i]  = live && !(val_q[i] < new_val);
    assign nxt_pri[i] = (POS == slot) ? new_rank :
                        bump[i]       ? pri_q[i] + IW'(1) : pri_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pri_q[i] <= '0;
        val_q[i] <= '0;
      end else if (push) begin
        pri_q[i] <= nxt_pri[i];
        if (POS == slot) val_q[i] <= new_val;
      end
    end
  end

  assign new_rank = IW'($countones(below));
endmodule

// File: rtl/perm_drain_stack.sv
module perm_drain_stack #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [N-1:0][IW-1:0] load_pri,
  input  logic [IW-1:0]        rd_ptr,
  output logic [IW-1:0]        rd_pri
);
  logic [N-1:0][IW-1:0] pri_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pri_q <= '0;
    else if (load) pri_q <= load_pri;
  end

  assign rd_pri = pri_q[rd_ptr];
endmodule

// File: rtl/perm_round_gen.sv
module perm_round_gen
  import perm_pkg::*;
#(
  parameter int N  = 16,
  parameter int VW = 4,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       seed,
  input  logic              en,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [IW-1:0]     out_index
);
  localparam logic [IW-1:0] LAST_SLOT = IW'(N - 1);

  phase_t               phase_q;
  logic [IW-1:0]        slot_q;
  logic                 step;
  logic                 round_end;
  logic [VW-1:0]        rnd_val;
  logic [N-1:0][IW-1:0] ranked;

  assign out_valid = en && (phase_q == PH_RUN);
  assign step      = en && ((phase_q == PH_FILL) || out_ready);
  assign round_end = step && (slot_q == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
      slot_q  <= '0;
    end else if (step) begin
      slot_q <= slot_q + IW'(1);
      if (round_end) phase_q <= PH_RUN;
    end
  end

  perm_lfsr #(.VW(VW)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .seed(seed), .adv(step), .value(rnd_val)
  );

  perm_fill_stack #(.N(N), .IW(IW), .VW(VW)) u_fill (
    .clk(clk), .rst_n(rst_n), .push(step), .slot(slot_q),
    .new_val(rnd_val), .nxt_pri(ranked)
  );

  perm_drain_stack #(.N(N), .IW(IW)) u_drain (
    .clk(clk), .rst_n(rst_n), .load(round_end), .load_pri(ranked),
    .rd_ptr(~slot_q), .rd_pri(out_index)
  );
endmodule

// File: rtl/perm_round_gen_chk.sv
module perm_round_gen_chk #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          out_ready,
  input logic          out_valid,
  input logic [IW-1:0] out_index
);
  logic [N-1:0]  seen_q;
  logic [IW-1:0] hs_cnt;
  logic          hs;

  assign hs = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0;
      hs_cnt <= '0;
    end else if (hs) begin
      hs_cnt <= hs_cnt + IW'(1);
      if (hs_cnt == IW'(N - 1)) seen_q <= '0;
      else seen_q[out_index] <= 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid);

  p_no_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (!en || out_valid));

  p_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> !seen_q[out_index]);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_index));

  p_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(out_index));
endmodule

bind perm_round_gen perm_round_gen_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .out_ready(out_ready),
  .out_valid(out_valid), .out_index(out_index)
);

// File: tb/sim_perm_round_gen.sv
module sim_perm_round_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int VW = 4;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   seed = 16'h0;
  logic          en = 1'b0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [IW-1:0] out_index;

  int checks = 0;
  int failures = 0;

  logic [15:0] m_lfsr;
  int          m_fill;
  bit          m_primed;
  int          exp_idx [N];
  int          pos;
  bit          seen [N];
  bit          prev_stall;
  int          prev_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_round_gen #(.N(N), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .seed(seed), .en(en),
    .out_ready(out_ready), .out_valid(out_valid), .out_index(out_index)
  );

  function automatic logic [15:0] adv(input logic [15:0] s);
    adv = s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R4: ranks of the next N values, stored in issue order
  task automatic gen_round();
    int v [N];
    for (int j = 0; j < N; j++) begin
      v[j] = int'(m_lfsr[VW-1:0]);
      m_lfsr = adv(m_lfsr);
    end
    for (int j = 0; j < N; j++) begin
      int r = 0;
      for (int k = 0; k < N; k++) begin
        if (k < j && v[k] < v[j]) r++;
        if (k > j && v[k] <= v[j]) r++;
      end
      exp_idx[N-1-j] = r;
    end
  endtask

  task automatic do_reset(input logic [15:0] s);
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; out_ready = 1'b0; seed = s;
    repeat (3) @(negedge clk);
    #1 check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    @(negedge clk);
    en = 1'b1;
    #1 check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    en = 1'b0;
    rst_n = 1'b1;
    m_lfsr = (s == 16'h0) ? 16'hACE1 : s;   // R7
    m_fill = 0; m_primed = 1'b0; pos = 0; prev_stall = 1'b0; prev_idx = 0;
    for (int i = 0; i < N; i++) seen[i] = 1'b0;
    gen_round();
  endtask

  task automatic cycle(input bit e, input bit r, input string tag);
    @(negedge clk);
    en = e; out_ready = r;
    #1;
    if (!e) check(out_valid == 1'b0, "R6", int'(out_valid), 0);
    else    check(out_valid == m_primed, "R2", int'(out_valid), int'(m_primed));
    if (prev_stall && out_valid)
      check(int'(out_index) == prev_idx, "R5", int'(out_index), prev_idx);
    if (out_valid && r) begin
      check(int'(out_index) == exp_idx[pos], tag, int'(out_index), exp_idx[pos]);
      check(!seen[out_index], "R3", int'(out_index), -1);
      seen[out_index] = 1'b1;
      pos++;
      if (pos == N) begin
        pos = 0;
        for (int i = 0; i < N; i++) seen[i] = 1'b0;
        gen_round();
      end
    end
    // R8: steps while filling need only en
    if (e && !m_primed) begin
      m_fill++;
      if (m_fill == N) m_primed = 1'b1;
    end
    prev_stall = out_valid && !r;
    prev_idx = int'(out_index);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(16'h1234);
    // R2 R4 R8: fill then back-to-back rounds
    for (int c = 0; c < 6 * N; c++) cycle(1'b1, 1'b1, "R4");
    // R5: back-pressure pattern
    for (int c = 0; c < 200; c++) cycle(1'b1, (c % 3) != 0, "R4");
    // R6: en gaps mixed with stalls
    for (int c = 0; c < 150; c++) cycle((c % 5) != 0, (c % 2) == 0, "R6");
    // R6: pause during the initial fill
    do_reset(16'h00F0);
    for (int c = 0; c < 4 * N; c++) cycle((c % 4) != 1, 1'b1, "R6");
    // R7: zero seed behaves as the fixed substitute
    do_reset(16'h0000);
    for (int c = 0; c < 4 * N; c++) cycle(1'b1, 1'b1, "R7");
    // R3 R4: seed sweep
    for (int s = 1; s <= 12; s++) begin
      do_reset(16'(s * 16'h1357));
      for (int c = 0; c < 4 * N; c++) cycle(1'b1, (c % 7) != 3, "R4");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule